// File: doc/BRIEF.md
# Window Watchdog Timer

This block supervises software timing using a 7-bit down-counter. The counter steps once per prescaler period. That period is a fixed power-of-two divide of the bus clock followed by a programmable divide of 1, 2, 4 and so on up to 128. After software arms the block, it must reload the counter inside a window. The window opens when the counter falls to or below a programmed window value, and it closes when bit 6 of the counter would drop. If a reload arrives too early, if the counter runs out, or if software writes a value with bit 6 clear, the block issues a one-cycle reset pulse. On the following cycle it returns every register to its power-up value.

When the counter reaches 0x40, an early-warning flag is raised so that software gets one last prescaler period to act. An interrupt output mirrors this flag when its enable is set. Software reaches the block through a simple register port: one write strobe with an address and write data, and combinational read data for the same address. There are three words. Offset 0x0 holds the counter and the arm bit. Offset 0x4 holds the window, timebase and interrupt enable. Offset 0x8 holds the warning flag.

Top module: `window_watchdog`

## Requirements
- R1: After reset, offset 0x0 reads 0x7F (arm bit 7 clear, counter bits 6:0 = 0x7F), offset 0x4 reads 0x7F (window 0x7F, timebase 0, interrupt enable 0), offset 0x8 reads 0, and both outputs are low.
- R2: The counter decreases by one every 2^FIX_DIV_LOG2 × 2^tb clock cycles, where tb is offset 0x4 bits 13:11. It wraps from 0x00 to 0x7F.
- R3: The counter runs even while the block is unarmed, and no reset pulse is produced while unarmed.
- R4: Writing 1 to offset 0x0 bit 7 arms the block. Writing 0 there has no effect. Only a system reset or the block's own reset pulse clears it.
- R5: When armed, the step of the counter from 0x40 to 0x3F raises the reset pulse in the same cycle the counter first reads 0x3F.
- R6: When armed, a write to offset 0x0 while the counter is greater than the window (offset 0x4 bits 6:0) raises the reset pulse in the next cycle. A counter equal to the window is allowed.
- R7: A write to offset 0x0 with bit 6 clear raises the reset pulse in the next cycle if the block is armed, including the case where that same write sets bit 7. When the block is unarmed, such a write only loads the counter.
- R8: A legal reload (counter at or below the window, bit 6 set) loads bits 6:0 without a pulse. The prescaler is not restarted, so the first step after a reload comes within one prescaler period.
- R9: The warning flag (offset 0x8 bit 0) is set when a step brings the counter to 0x40, whether or not the interrupt is enabled. Writing 0 clears it, and writing 1 has no effect.
- R10: The interrupt output equals flag AND enable, where the enable is offset 0x4 bit 9. Software can set the enable, and only a reset clears it.
- R11: The reset pulse is high for exactly one cycle. In the following cycle all registers read their R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Byte offset of the register word |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for regAddr (combinational) |
| wdReset | output | 1 | Registered one-cycle watchdog reset pulse |
| earlyIrq | output | 1 | Early-warning interrupt |

## Verification
Reloads are tried at several counter positions. A reload one count above the window must fire, and a reload exactly at the window must not, which separates the strict-greater compare from an off-by-one. The same reload values are written both unarmed and armed, including a value with bit 6 clear, to show that arming alone gates every reset cause. Counter step intervals are measured under three timebase settings to tell the tap selection apart. Letting an armed counter run out shows that the pulse and the flag line up with 0x3F and 0x40 respectively.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
  localparam int CNT_W  = 7;
  localparam int TB_W   = 3;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_CFG  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_STAT = 4'h8;

  localparam int EN_BIT    = 7;
  localparam int TB_LSB    = 11;
  localparam int IRQEN_BIT = 9;
  localparam int FLAG_BIT  = 0;

  // Counter value at which the warning flag is raised; bit 6 alone.
  localparam logic [CNT_W-1:0] CNT_WARN = CNT_W'(1) << (CNT_W - 1);

  // Strobes from control to datapath.
  typedef struct packed {
    logic             restore;
    logic             load;
    logic [CNT_W-1:0] loadVal;
  } dpCmd_t;

  // Observations from datapath back to control.
  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic             aboveWindow;
    logic             reachWarn;
    logic             expireStep;
  } dpStat_t;
endpackage

// File: rtl/wwd_datapath.sv
module wwd_datapath
  import wwd_pkg::*;
#(
  parameter int FIX_DIV_LOG2 = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic [TB_W-1:0]  timeBase,
  input  logic [CNT_W-1:0] windowVal,
  output dpStat_t          stat
);
  localparam int TAPS  = 1 << TB_W;
  localparam int PRE_W = FIX_DIV_LOG2 + TAPS - 1;

  logic [PRE_W-1:0] preCnt;
  logic [TAPS-1:0]  tickSel;
  logic             tick;
  logic [CNT_W-1:0] cnt;

  // Free-running prescaler; only a full restore clears it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            preCnt <= '0;
    else if (cmd.restore) preCnt <= '0;
    else                  preCnt <= preCnt + PRE_W'(1);
  end

  // One tap per timebase setting: tick when the low bits are all ones.
  generate
    for (genvar g = 0; g < TAPS; g++) begin : gTap
      assign tickSel[g] = &preCnt[FIX_DIV_LOG2+g-1:0];
    end
  endgenerate

  assign tick = tickSel[timeBase];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '1;
    else if (cmd.restore) cnt <= '1;
    else if (cmd.load)    cnt <= cmd.loadVal;
    else if (tick)        cnt <= cnt - CNT_W'(1);
  end

  logic stepNow;
  assign stepNow = tick && !cmd.load && !cmd.restore;

  assign stat.cnt         = cnt;
  assign stat.aboveWindow = cnt > windowVal;
  assign stat.reachWarn   = stepNow && (cnt == CNT_WARN + CNT_W'(1));
  assign stat.expireStep  = stepNow && (cnt == CNT_WARN);
endmodule

// File: rtl/wwd_control.sv
module wwd_control
  import wwd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  dpStat_t           stat,
  output dpCmd_t            cmd,
  output logic [TB_W-1:0]   timeBase,
  output logic [CNT_W-1:0]  windowVal,
  output logic [DATA_W-1:0] rdData,
  output logic              wdReset,
  output logic              earlyIrq,
  output logic              enLatch,
  output logic              irqEn,
  output logic              warnFlag
);
  logic rstPulse;
  logic wrCtrl, wrCfg, wrStat;
  logic effEn, earlyLoad, lowLoad, fireNow;
  logic unusedWrBits;

  assign unusedWrBits = ^{wrData[DATA_W-1:TB_LSB+TB_W], wrData[TB_LSB-1], wrData[IRQEN_BIT-1]};

  // Writes are dropped during the pulse cycle; the restore wins.
  assign wrCtrl = wrEn && !rstPulse && (regAddr == OFS_CTRL);
  assign wrCfg  = wrEn && !rstPulse && (regAddr == OFS_CFG);
  assign wrStat = wrEn && !rstPulse && (regAddr == OFS_STAT);

  // Arming takes effect for the write that sets it.
  assign effEn     = enLatch || (wrCtrl && wrData[EN_BIT]);
  assign earlyLoad = wrCtrl && stat.aboveWindow;
  assign lowLoad   = wrCtrl && !wrData[CNT_W-1];
  assign fireNow   = !rstPulse && effEn && (earlyLoad || lowLoad || stat.expireStep);

  assign cmd.restore = rstPulse;
  assign cmd.load    = wrCtrl;
  assign cmd.loadVal = wrData[CNT_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstPulse <= 1'b0;
    else       rstPulse <= fireNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enLatch   <= 1'b0;
      irqEn     <= 1'b0;
      warnFlag  <= 1'b0;
      timeBase  <= '0;
      windowVal <= '1;
    end else if (rstPulse) begin
      enLatch   <= 1'b0;
      irqEn     <= 1'b0;
      warnFlag  <= 1'b0;
      timeBase  <= '0;
      windowVal <= '1;
    end else begin
      if (wrCtrl && wrData[EN_BIT]) enLatch <= 1'b1;
      if (wrCfg) begin
        timeBase  <= wrData[TB_LSB +: TB_W];
        windowVal <= wrData[CNT_W-1:0];
        if (wrData[IRQEN_BIT]) irqEn <= 1'b1;
      end
      if (stat.reachWarn)                     warnFlag <= 1'b1;
      else if (wrStat && !wrData[FLAG_BIT])   warnFlag <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    case (regAddr)
      OFS_CTRL: begin
        rdData[EN_BIT]      = enLatch;
        rdData[CNT_W-1:0]   = stat.cnt;
      end
      OFS_CFG: begin
        rdData[TB_LSB +: TB_W] = timeBase;
        rdData[IRQEN_BIT]      = irqEn;
        rdData[CNT_W-1:0]      = windowVal;
      end
      OFS_STAT: rdData[FLAG_BIT] = warnFlag;
      default:  rdData = '0;
    endcase
  end

  assign wdReset  = rstPulse;
  assign earlyIrq = warnFlag && irqEn;
endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
  import wwd_pkg::*;
#(
  parameter int FIX_DIV_LOG2 = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              wdReset,
  output logic              earlyIrq
);
  dpCmd_t           dpCmd;
  dpStat_t          dpStat;
  logic [TB_W-1:0]  timeBase;
  logic [CNT_W-1:0] windowVal;
  logic [CNT_W-1:0] cntVal;
  logic             enLatch, irqEn, warnFlag;

  wwd_control u_control (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .stat(dpStat), .cmd(dpCmd), .timeBase(timeBase), .windowVal(windowVal),
    .rdData(rdData), .wdReset(wdReset), .earlyIrq(earlyIrq),
    .enLatch(enLatch), .irqEn(irqEn), .warnFlag(warnFlag)
  );

  wwd_datapath #(.FIX_DIV_LOG2(FIX_DIV_LOG2)) u_datapath (
    .clk(clk), .rstN(rstN), .cmd(dpCmd), .timeBase(timeBase),
    .windowVal(windowVal), .stat(dpStat)
  );

  assign cntVal = dpStat.cnt;
endmodule

// File: rtl/wwd_checker.sv
module wwd_checker
  import wwd_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              wdReset,
  input logic              earlyIrq,
  input logic [CNT_W-1:0]  cntVal,
  input logic              enLatch,
  input logic              irqEn,
  input logic              warnFlag
);
  logic ctrlWr;
  assign ctrlWr = wrEn && (regAddr == OFS_CTRL);

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    wdReset |=> !wdReset); // R11
  AST_RESTORE_VALUES: assert property (@(posedge clk) disable iff (!rstN)
    wdReset |=> (cntVal == '1 && !enLatch && !irqEn && !warnFlag)); // R11
  AST_NO_PULSE_UNARMED: assert property (@(posedge clk) disable iff (!rstN)
    (!enLatch && !(ctrlWr && wrData[EN_BIT])) |=> !wdReset); // R3
  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (enLatch && !wdReset) |=> enLatch); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!wdReset && !ctrlWr) |=> (cntVal == $past(cntVal) || cntVal == $past(cntVal) - CNT_W'(1))); // R2
  AST_LOW_LOAD_FIRES: assert property (@(posedge clk) disable iff (!rstN)
    (!wdReset && ctrlWr && wrData[EN_BIT] && !wrData[CNT_W-1]) |=> wdReset); // R7
  AST_FLAG_AT_WARN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(warnFlag) |-> (cntVal == CNT_WARN)); // R9
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    earlyIrq |-> irqEn); // R10
endmodule

bind window_watchdog wwd_checker u_wwdChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
  .wdReset(wdReset), .earlyIrq(earlyIrq), .cntVal(cntVal),
  .enLatch(enLatch), .irqEn(irqEn), .warnFlag(warnFlag)
);

// File: tb/window_watchdog_bench.sv
module window_watchdog_bench;
  import wwd_pkg::*;

  localparam int FIX_LOG2 = 4;
  localparam int BASE_P   = 1 << FIX_LOG2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic              wdReset;
  logic              earlyIrq;

  int checks = 0;
  int failures = 0;
  int pulseCnt = 0;

  always #4 clk = ~clk;

  window_watchdog #(.FIX_DIV_LOG2(FIX_LOG2)) u_window_watchdog (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .wdReset(wdReset), .earlyIrq(earlyIrq)
  );

  always @(posedge clk) if (rstN && wdReset) pulseCnt++;

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; wrEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // Called at a negedge; returns at the negedge after the capturing edge.
  task automatic regWrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] v);
    regAddr = a;
    #1 v = rdData;
  endtask

  task automatic waitCnt(input logic [6:0] target, input string req);
    logic [31:0] r;
    int n = 0;
    readReg(OFS_CTRL, r);
    while (r[6:0] != target && n < 6000) begin
      @(negedge clk); readReg(OFS_CTRL, r); n++;
    end
    checkEq(req, {25'd0, r[6:0]}, {25'd0, target});
  endtask

  task automatic measureGap(output int gap);
    logic [31:0] r;
    logic [6:0] c0;
    int n = 0;
    readReg(OFS_CTRL, r); c0 = r[6:0];
    while (r[6:0] == c0 && n < 6000) begin @(negedge clk); readReg(OFS_CTRL, r); n++; end
    c0 = r[6:0]; gap = 0;
    while (r[6:0] == c0 && gap < 6000) begin @(negedge clk); readReg(OFS_CTRL, r); gap++; end
  endtask

  task automatic testResetState();
    logic [31:0] r;
    doReset();
    readReg(OFS_CTRL, r); checkEq("R1 ctrl", r, 32'h7F);
    readReg(OFS_CFG, r);  checkEq("R1 cfg", r, 32'h7F);
    readReg(OFS_STAT, r); checkEq("R1 stat", r, 32'h0);
    checkEq("R1 outputs", {30'd0, wdReset, earlyIrq}, 32'h0);
  endtask

  task automatic testTimebase();
    int gap;
    doReset();
    measureGap(gap); checkEq("R2 tb0 gap", gap, BASE_P);
    regWrite(OFS_CFG, (32'd2 << TB_LSB) | 32'h7F);
    measureGap(gap); checkEq("R2 tb2 gap", gap, BASE_P * 4);
    regWrite(OFS_CFG, (32'd7 << TB_LSB) | 32'h7F);
    measureGap(gap); checkEq("R2 tb7 gap", gap, BASE_P * 128);
  endtask

  task automatic testUnarmedRun();
    logic [31:0] r;
    int p0;
    doReset();
    p0 = pulseCnt;
    regWrite(OFS_CTRL, 32'h42);          // unarmed load
    waitCnt(7'h3E, "R3 passes 0x3F unarmed");
    checkEq("R3 no pulse unarmed", pulseCnt - p0, 0);
    readReg(OFS_STAT, r); checkEq("R9 flag set without irq enable", r, 32'h1);
    checkEq("R10 irq gated off", {31'd0, earlyIrq}, 32'h0);
    regWrite(OFS_STAT, 32'h1);
    readReg(OFS_STAT, r); checkEq("R9 write 1 keeps flag", r, 32'h1);
    regWrite(OFS_STAT, 32'h0);
    readReg(OFS_STAT, r); checkEq("R9 write 0 clears flag", r, 32'h0);
    regWrite(OFS_CTRL, 32'h01);
    waitCnt(7'h7F, "R2 wraps 0x00 to 0x7F");
    checkEq("R3 no pulse across wrap", pulseCnt - p0, 0);
  endtask

  task automatic testArmSticky();
    logic [31:0] r;
    doReset();
    regWrite(OFS_CTRL, 32'hFF);
    regWrite(OFS_CTRL, 32'h7F);
    readReg(OFS_CTRL, r); checkEq("R4 arm ignores write 0", r, 32'hFF);
    doReset();
    readReg(OFS_CTRL, r); checkEq("R4 system reset disarms", r[7], 0);
  endtask

  task automatic testEarlyReload();
    logic [31:0] r;
    doReset();
    regWrite(OFS_CTRL, 32'hFF);
    regWrite(OFS_CFG, 32'h50);
    waitCnt(7'h51, "R6 reach window+1");
    regWrite(OFS_CTRL, 32'hFF);
    checkEq("R6 pulse on early reload", {31'd0, wdReset}, 32'h1);
    @(negedge clk);
    checkEq("R11 pulse one cycle", {31'd0, wdReset}, 32'h0);
    readReg(OFS_CFG, r);  checkEq("R11 cfg restored", r, 32'h7F);
    readReg(OFS_CTRL, r); checkEq("R11 ctrl restored", r, 32'h7F);
  endtask

  task automatic testLegalReload();
    logic [31:0] r;
    int p0, gap;
    doReset();
    regWrite(OFS_CTRL, 32'hFF);
    regWrite(OFS_CFG, 32'h50);
    waitCnt(7'h50, "R8 reach window");
    p0 = pulseCnt;
    regWrite(OFS_CTRL, 32'hFF);
    checkEq("R8 no pulse at window", {31'd0, wdReset}, 32'h0);
    readReg(OFS_CTRL, r); checkEq("R8 reload value", r, 32'hFF);
    gap = 0;
    while (r[6:0] == 7'h7F && gap < 100) begin @(negedge clk); readReg(OFS_CTRL, r); gap++; end
    checkEq("R8 first step within one period", gap <= BASE_P, 1);
    checkEq("R8 no pulse after", pulseCnt - p0, 0);
  endtask

  task automatic testLowLoad();
    logic [31:0] r;
    int p0;
    doReset();
    p0 = pulseCnt;
    regWrite(OFS_CTRL, 32'h30);
    readReg(OFS_CTRL, r); checkEq("R7 unarmed low load", r, 32'h30);
    checkEq("R7 no pulse unarmed", pulseCnt - p0, 0);
    regWrite(OFS_CTRL, 32'hB0);
    checkEq("R7 arm plus low load fires", {31'd0, wdReset}, 32'h1);
    @(negedge clk);
    regWrite(OFS_CTRL, 32'hFF);
    regWrite(OFS_CTRL, 32'h20);
    checkEq("R7 armed low load fires", {31'd0, wdReset}, 32'h1);
    @(negedge clk);
  endtask

  task automatic testTimeout();
    logic [31:0] r;
    int n = 0;
    doReset();
    regWrite(OFS_CFG, (32'd1 << IRQEN_BIT) | 32'h7F);
    regWrite(OFS_CFG, 32'h7F);
    readReg(OFS_CFG, r); checkEq("R10 irq enable sticky", r, (32'd1 << IRQEN_BIT) | 32'h7F);
    regWrite(OFS_CTRL, 32'hC3);
    waitCnt(7'h40, "R5 reach 0x40");
    readReg(OFS_STAT, r); checkEq("R9 flag at 0x40", r, 32'h1);
    checkEq("R10 irq high", {31'd0, earlyIrq}, 32'h1);
    checkEq("R5 no pulse yet", {31'd0, wdReset}, 32'h0);
    readReg(OFS_CTRL, r);
    while (r[6:0] == 7'h40 && n < 100) begin @(negedge clk); readReg(OFS_CTRL, r); n++; end
    checkEq("R5 counter 0x3F", r[6:0], 7'h3F);
    checkEq("R5 pulse with 0x3F", {31'd0, wdReset}, 32'h1);
    @(negedge clk);
    checkEq("R11 pulse ends", {31'd0, wdReset}, 32'h0);
    readReg(OFS_STAT, r); checkEq("R11 flag restored", r, 32'h0);
    readReg(OFS_CFG, r);  checkEq("R11 cfg restored", r, 32'h7F);
    checkEq("R10 irq low after restore", {31'd0, earlyIrq}, 32'h0);
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog timeout act=0x0 exp=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    testResetState();
    testTimebase();
    testUnarmedRun();
    testArmSticky();
    testEarlyReload();
    testLegalReload();
    testLowLoad();
    testTimeout();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule